// File: doc/BRIEF.md
# ASK Carrier Sine Code Generator

This block turns an oscillator clock into a stream of 4-bit sine codes for the transmit side of an amplitude-shift-keyed link. An external 4-bit converter turns the codes into the carrier. A second output carries the mirrored waveform, for a differential or push-pull output stage. An enable input gates the carrier on and off. A parameter sets whether that enable is active high or active low.

A rate-select input picks the carrier frequency: the oscillator divided by 16 or by 32. The generator steps through a 16-entry sine table once per master-clock tick. The master clock is the oscillator itself at the fast rate and the oscillator divided by two at the slow rate. When the carrier is gated off, both code outputs park at mid-scale. Every burst restarts at table index 0, so all bursts begin with the same phase.

Reset is asynchronous and active low. A drive flag tells the pad logic when the outputs may leave high impedance. A reference clock output supplies either the oscillator clock or half of it.

Top module: `ask_sine_gen`

## Requirements
- R1: While rst_ni is low, sine_o is 8, sine_n_o is 7, burst_o is 0 and pad_oe_o is 0 (pads high impedance).
- R2: pad_oe_o becomes 1 at the first rising clock edge after reset release and stays 1 until the next reset.
- R3: With rate_sel_i low, one table step is taken on every clock edge. The table over indices 0..15 is 8,11,13,14,15,14,13,11,8,5,3,2,1,2,3,5, which gives a carrier period of 16 clocks.
- R4: With rate_sel_i high, a divide-by-2 phase bit is used. It is 0 at reset release and toggles on every rising edge. A table step is taken only on edges where this bit is 1, so each code lasts 2 clocks and the carrier period is 32 clocks.
- R5: The enable is active when en_i equals the parameter EN_ACT_HIGH. The inactive level of en_i keeps the generator parked however long it is held.
- R6: Once the enable is active, burst_o rises no later than 2 master-clock cycles afterwards.
- R7: Once the enable is inactive, burst_o falls and both codes return to parked values (8 and 7) no later than 2 master-clock cycles afterwards.
- R8: sine_n_o always equals 15 minus sine_o.
- R9: ref_clk_o follows clk_i when ref_half_i is low. When ref_half_i is high, it equals the divide-by-2 phase bit of R4.
- R10: Every burst starts at table index 0: in the first cycle with burst_o high, sine_o is 8, and the next step gives 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Carrier enable; polarity set by EN_ACT_HIGH |
| rate_sel_i | input | 1 | 0: carrier = clock/16, 1: carrier = clock/32 |
| ref_half_i | input | 1 | 0: ref_clk_o = clock, 1: ref_clk_o = clock/2 |
| sine_o | output | 4 | Sine code to the converter |
| sine_n_o | output | 4 | Mirrored sine code (15 - sine_o) |
| burst_o | output | 1 | Carrier running |
| pad_oe_o | output | 1 | Pad drive enable, low means high impedance |
| ref_clk_o | output | 1 | Reference clock output |

## Verification
The bench builds the block with EN_ACT_HIGH set to 0. This makes a high level on en_i the idle state and checks that the polarity is decoded rather than assumed. Both rate settings and both reference-clock settings are exercised against a behavioural model. This covers the worst-case gating latency at the slow rate, where enable can arrive just after a tick. Short and back-to-back bursts and a reset in mid-burst show that the phase restarts and that parking holds.

// File: rtl/ask_sine_pkg.sv
package ask_sine_pkg;
  localparam int CODE_W = 4;
  localparam int IDX_W  = 4;
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1 << (CODE_W-1));
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  // amplitude above mid-scale for phase steps 0..4 of a quarter wave
  function automatic logic [CODE_W-1:0] quarter_amp(input logic [2:0] k);
    case (k)
      3'd0:    return CODE_W'(0);
      3'd1:    return CODE_W'(3);
      3'd2:    return CODE_W'(5);
      3'd3:    return CODE_W'(6);
      default: return CODE_W'(7);
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] sine_code(input logic [IDX_W-1:0] idx);
    logic [1:0]        quad;
    logic [2:0]        k;
    logic [CODE_W-1:0] amp;
    quad = idx[IDX_W-1 -: 2];
    k    = {1'b0, idx[1:0]};
    amp  = quad[0] ? quarter_amp(3'd4 - k) : quarter_amp(k);
    return quad[1] ? (CODE_MID - amp) : (CODE_MID + amp);
  endfunction
endpackage

// File: rtl/ask_mclk_div.sv
module ask_mclk_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_sel_i,
  input  logic ref_half_i,
  output logic tick_o,
  output logic ref_clk_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  assign tick_o    = ~rate_sel_i | phase_q;
  assign ref_clk_o = ref_half_i ? phase_q : clk_i;
endmodule

// File: rtl/ask_burst_seq.sv
module ask_burst_seq #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_on_i,
  output logic             run_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             run_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      idx_q <= '0;
    end else if (tick_i) begin
      if (!gate_on_i) begin
        run_q <= 1'b0;
        idx_q <= '0;
      end else if (!run_q) begin
        run_q <= 1'b1;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign run_o = run_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/ask_code_map.sv
module ask_code_map
  import ask_sine_pkg::*;
(
  input  logic              run_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] code_n_o
);
  always_comb begin
    code_o   = run_i ? sine_code(idx_i) : CODE_MID;
    code_n_o = CODE_MAX - code_o;
  end
endmodule

// File: rtl/ask_sine_gen.sv
module ask_sine_gen
  import ask_sine_pkg::*;
#(
  parameter bit EN_ACT_HIGH = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rate_sel_i,
  input  logic              ref_half_i,
  output logic [CODE_W-1:0] sine_o,
  output logic [CODE_W-1:0] sine_n_o,
  output logic              burst_o,
  output logic              pad_oe_o,
  output logic              ref_clk_o
);
  logic             tick;
  logic             gate_on;
  logic             run;
  logic [IDX_W-1:0] idx;
  logic             oe_q;

  generate
    if (EN_ACT_HIGH) begin : g_en_hi
      assign gate_on = en_i;
    end else begin : g_en_lo
      assign gate_on = ~en_i;
    end
  endgenerate

  ask_mclk_div u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_sel_i (rate_sel_i),
    .ref_half_i (ref_half_i),
    .tick_o     (tick),
    .ref_clk_o  (ref_clk_o)
  );

  ask_burst_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .gate_on_i (gate_on),
    .run_o     (run),
    .idx_o     (idx)
  );

  ask_code_map u_map (
    .run_i    (run),
    .idx_i    (idx),
    .code_o   (sine_o),
    .code_n_o (sine_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= 1'b1;
  end

  assign burst_o  = run;
  assign pad_oe_o = oe_q;
endmodule

// File: rtl/ask_sine_gen_chk.sv
module ask_sine_gen_chk #(
  parameter bit EN_ACT_HIGH = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [3:0] sine_o,
  input logic [3:0] sine_n_o,
  input logic       burst_o,
  input logic       pad_oe_o
);
  logic       act;
  logic [2:0] on_wait, off_wait;

  assign act = (en_i == EN_ACT_HIGH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_wait  <= '0;
      off_wait <= '0;
    end else begin
      on_wait  <= (act && !burst_o)  ? ((on_wait == 3'd7)  ? on_wait  : on_wait + 3'd1)  : 3'd0;
      off_wait <= (!act && burst_o) ? ((off_wait == 3'd7) ? off_wait : off_wait + 3'd1) : 3'd0;
    end
  end

  assert_on_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_wait <= 3'd3);

  assert_off_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_wait <= 3'd3);

  assert_park_mid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_o |-> (sine_o == 4'd8 && sine_n_o == 4'd7));

  assert_mirror_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sine_n_o == 4'(4'd15 - sine_o));

  assert_burst_phase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(burst_o) |-> sine_o == 4'd8);

  assert_oe_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o |=> pad_oe_o);
endmodule

bind ask_sine_gen ask_sine_gen_chk #(.EN_ACT_HIGH(EN_ACT_HIGH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .sine_o   (sine_o),
  .sine_n_o (sine_n_o),
  .burst_o  (burst_o),
  .pad_oe_o (pad_oe_o)
);

// File: tb/ask_sine_gen_tb.sv
module ask_sine_gen_tb;
  localparam int CLK_P = 10;
  localparam bit ACT   = 1'b0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       en = ~ACT;
  logic       rate = 1'b0;
  logic       refh = 1'b0;
  logic [3:0] sine, sine_n;
  logic       burst, oe, refclk;

  int vecs = 0, fails = 0;
  bit started = 0;

  int tbl [16] = '{8, 11, 13, 14, 15, 14, 13, 11, 8, 5, 3, 2, 1, 2, 3, 5};
  int m_phase = 0, m_run = 0, m_idx = 0, m_oe = 0;

  always #(CLK_P/2) clk = ~clk;

  ask_sine_gen #(.EN_ACT_HIGH(ACT)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .rate_sel_i (rate),
    .ref_half_i (refh), .sine_o (sine), .sine_n_o (sine_n),
    .burst_o (burst), .pad_oe_o (oe), .ref_clk_o (refclk)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_run = 0; m_idx = 0; m_oe = 0;
    end else begin
      bit tk;
      tk = (rate == 1'b0) || (m_phase == 1);
      m_phase = 1 - m_phase;
      m_oe = 1;
      if (tk) begin
        if (en != ACT) begin m_run = 0; m_idx = 0; end
        else if (m_run == 0) begin m_run = 1; m_idx = 0; end
        else m_idx = (m_idx + 1) % 16;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      int es;
      string rq;
      es = m_run ? tbl[m_idx] : 8;
      rq = !rst_n ? "R1" : (!m_run ? "R7" : (rate ? "R4" : "R3"));
      chk(rq, int'(sine), es);
      chk("R8", int'(sine_n), 15 - es);
      chk(!rst_n ? "R1" : "R6", int'(burst), m_run);
      chk(!rst_n ? "R1" : "R2", int'(oe), m_oe);
    end
  end

  // reference clock sampled in the high half of each clock
  always @(posedge clk) begin
    #1;
    if (started) chk("R9", int'(refclk), refh ? m_phase : 1);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic burst_on(input string req);
    int cnt = 0;
    en = ACT;
    while (cnt < 10) begin
      @(negedge clk);
      cnt++;
      if (burst) break;
    end
    chk({req, " on latency ok"}, int'(cnt <= (rate ? 4 : 2)), 1);
    chk("R10 first code", int'(sine), 8);
    #1;
  endtask

  task automatic burst_off();
    int cnt = 0;
    en = ~ACT;
    while (cnt < 10) begin
      @(negedge clk);
      cnt++;
      if (!burst) break;
    end
    chk("R7 off latency ok", int'(cnt <= (rate ? 4 : 2)), 1);
    chk("R7 parked", int'(sine), 8);
    #1;
  endtask

  initial begin
    #(CLK_P*200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    started = 1;
    step(3);
    chk("R1 reset oe", int'(oe), 0);
    chk("R1 reset sine", int'(sine), 8);
    rst_n = 1'b1;
    step(1);
    chk("R2 oe after release", int'(oe), 1);
    // R5: inactive level (high) keeps parked
    step(20);
    chk("R5 idle burst", int'(burst), 0);
    chk("R5 idle sine", int'(sine), 8);
    // R3 fast rate, full periods
    burst_on("R6");
    step(40);
    burst_off();
    step(5);
    // R4 slow rate, half ref clock
    rate = 1'b1; refh = 1'b1;
    step(3);
    burst_on("R6");
    step(70);
    burst_off();
    step(1);
    // odd alignment of enable versus phase
    burst_on("R6");
    step(9);
    burst_off();
    // short back-to-back bursts, R10 phase restart
    rate = 1'b0;
    for (int i = 0; i < 4; i++) begin
      burst_on("R10");
      step(i + 1);
      burst_off();
    end
    refh = 1'b0;
    // reset in mid-burst
    rate = 1'b1;
    burst_on("R6");
    step(11);
    rst_n = 1'b0;
    step(2);
    chk("R1 mid-burst reset", int'(burst), 0);
    chk("R1 mid-burst oe", int'(oe), 0);
    rst_n = 1'b1;
    step(40);
    burst_off();
    step(4);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule